// File: doc/BRIEF.md
# Interrupt Trigger-Mode Control Register

This block keeps the per-line trigger-mode selection for the sixteen interrupt lines of a PC-compatible interrupt subsystem built from two cascaded controllers. Two byte-wide registers at consecutive I/O ports hold one bit per line. A bit set to 1 marks the line as level-triggered and a bit set to 0 marks it as edge-triggered. The lower port covers lines 0 to 7 and the upper port covers lines 8 to 15. Writes pass through a per-register mask before they are stored, so the bits for lines that the architecture fixes as edge-only can never be set. A combinational query port reports the mode of any line.

When the platform has no interrupt steering (`steer_en_i` low), both ports stop decoding and the per-line registers no longer decide the mode. Each line then follows the global trigger-mode bit of the controller that serves it: the primary controller for lines 0 to 7 and the secondary controller for lines 8 to 15.

The block also tracks which of the PCI slots currently hold each shared level-triggered line. The first assertion from a slot on a level line is accepted and recorded. A repeat from the same slot is reported as not taken. The line stays active until every holding slot has released it.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: A write to port 0x4D0 stores the data ANDed with 0xF8, and a write to port 0x4D1 stores the data ANDed with 0xDE. Address bit 0 selects the register. A read strobe loads the selected stored value into `rdata_o` at the next clock edge, and `rdata_o` holds its value while no read strobe is present.
- R2: Writes to any address other than 0x4D0 and 0x4D1 change no register. A read strobe at such an address loads 0x00 into `rdata_o`.
- R3: With `steer_en_i` high, `query_level_o` for line n equals bit (n mod 8) of the lower register when n < 8, and of the upper register when n >= 8.
- R4: With `steer_en_i` high, lines 0, 1, 2, 8 and 13 report edge (0), whatever the register contents.
- R5: With `steer_en_i` low, lines 0 to 7 report `pri_level_mode_i` and lines 8 to 15 report `sec_level_mode_i`. This includes lines 0, 1, 2, 8 and 13.
- R6: With `steer_en_i` low, writes to both ports are ignored, and a read strobe at either port loads 0x00 into `rdata_o`.
- R7: Asynchronous reset clears both registers to 0x00, so every line reads back edge, and it clears all slot holds.
- R8: On a level-triggered line, an assertion from a slot that does not hold the line gives `assert_taken_o`=1 in that cycle and records the hold at the next edge. An assertion from a slot that already holds the line gives `assert_taken_o`=0.
- R9: On an edge-triggered line, every assertion gives `assert_taken_o`=1 and records no hold.
- R10: Bit n of `line_active_o` is 1 while any slot holds line n. A release clears only the releasing slot's hold, and a release in the same cycle as an assertion of the same slot and line takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| steer_en_i | input | 1 | Interrupt steering present: enables the port decode and the per-line registers |
| pri_level_mode_i | input | 1 | Global trigger-mode bit of the primary controller (1 = level) |
| sec_level_mode_i | input | 1 | Global trigger-mode bit of the secondary controller (1 = level) |
| addr_i | input | 16 | I/O address |
| wr_i | input | 1 | One-cycle write strobe |
| rd_i | input | 1 | One-cycle read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| query_irq_i | input | 4 | Line number for the mode query |
| query_level_o | output | 1 | 1 when the queried line is level-triggered |
| assert_vld_i | input | 1 | A slot asserts an interrupt line |
| assert_slot_i | input | 5 | Asserting slot number |
| assert_irq_i | input | 4 | Asserted line number |
| assert_taken_o | output | 1 | The assertion causes action (not a repeat on a held level line) |
| release_vld_i | input | 1 | A slot releases an interrupt line |
| release_slot_i | input | 5 | Releasing slot number |
| release_irq_i | input | 4 | Released line number |
| line_active_o | output | 16 | Per line: at least one slot holds it |

## Verification
The write-mask path is driven with all-ones, alternating and single-bit patterns to both ports, so that a swapped mask, a wrong select bit or missing masking each gives a distinct readback. The mode query covers lines that follow a register bit, lines that are fixed as edge-only, and the fallback with the two controller bits set to opposite values, so that a swapped controller or a fixed line that leaks through shows up. The hold tracking is run with two slots sharing one level line and released one at a time, with a repeat from the same slot, and with assertions on an edge line. This separates per-slot bookkeeping from a single shared flag.

// File: rtl/itc_pkg.sv
package itc_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned NUM_REG = 2;
  localparam int unsigned NUM_IRQ = REG_W * NUM_REG;
  localparam int unsigned IRQ_W   = $clog2(NUM_IRQ);

  typedef logic [REG_W-1:0] reg_byte_t;
endpackage

// File: rtl/itc_regfile.sv
module itc_regfile #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h04D0,
  parameter logic [7:0]  LO_MASK   = 8'hF8,
  parameter logic [7:0]  HI_MASK   = 8'hDE
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   steer_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  itc_pkg::reg_byte_t     wdata_i,
  output itc_pkg::reg_byte_t     rdata_o,
  output logic [itc_pkg::NUM_IRQ-1:0] mode_bits_o
);
  import itc_pkg::*;

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  reg_byte_t regs_q [NUM_REG];
  reg_byte_t rdata_q;
  logic      hit;
  logic      sel;

  assign hit = steer_en_i && (addr_i[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
  assign sel = addr_i[0];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    localparam reg_byte_t MASK = (r == 0) ? LO_MASK : HI_MASK;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[r] <= '0;
      end else if (wr_i && hit && (sel == 1'(r))) begin
        regs_q[r] <= wdata_i & MASK;
      end
    end
    assign mode_bits_o[r*REG_W +: REG_W] = regs_q[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= hit ? regs_q[sel] : '0;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/itc_mode_lookup.sv
module itc_mode_lookup #(
  parameter logic [15:0] FIXED_EDGE = 16'h2107
) (
  input  logic                        steer_en_i,
  input  logic                        pri_level_mode_i,
  input  logic                        sec_level_mode_i,
  input  logic [itc_pkg::NUM_IRQ-1:0] mode_bits_i,
  output logic [itc_pkg::NUM_IRQ-1:0] line_level_o
);
  import itc_pkg::*;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic ctrl_bit;
    assign ctrl_bit = (i < REG_W) ? pri_level_mode_i : sec_level_mode_i;
    if (FIXED_EDGE[i]) begin : g_fixed
      // fixed edge only when per-line control is active
      assign line_level_o[i] = steer_en_i ? 1'b0 : ctrl_bit;
    end else begin : g_free
      assign line_level_o[i] = steer_en_i ? mode_bits_i[i] : ctrl_bit;
    end
  end
endmodule

// File: rtl/itc_hold_tracker.sv
module itc_hold_tracker #(
  parameter int unsigned NUM_SLOTS = 32,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [itc_pkg::NUM_IRQ-1:0] line_level_i,
  input  logic                        assert_vld_i,
  input  logic [SLOT_W-1:0]           assert_slot_i,
  input  logic [itc_pkg::IRQ_W-1:0]   assert_irq_i,
  input  logic                        release_vld_i,
  input  logic [SLOT_W-1:0]           release_slot_i,
  input  logic [itc_pkg::IRQ_W-1:0]   release_irq_i,
  output logic                        assert_taken_o,
  output logic [itc_pkg::NUM_IRQ-1:0] line_active_o
);
  import itc_pkg::*;

  logic [NUM_SLOTS-1:0] hold_q [NUM_IRQ];
  logic [NUM_SLOTS-1:0] set_oh;
  logic [NUM_SLOTS-1:0] clr_oh;

  assign set_oh = NUM_SLOTS'(1) << assert_slot_i;
  assign clr_oh = NUM_SLOTS'(1) << release_slot_i;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic set_en;
    logic clr_en;
    assign set_en = assert_vld_i && (assert_irq_i == IRQ_W'(i)) && line_level_i[i];
    assign clr_en = release_vld_i && (release_irq_i == IRQ_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[i] <= '0;
      end else if (set_en || clr_en) begin
        hold_q[i] <= (hold_q[i] | (set_en ? set_oh : '0)) & ~(clr_en ? clr_oh : '0);
      end
    end

    assign line_active_o[i] = |hold_q[i];
  end

  logic [NUM_SLOTS-1:0] sel_hold;
  assign sel_hold = hold_q[assert_irq_i];

  assign assert_taken_o = assert_vld_i &&
                          !(line_level_i[assert_irq_i] && sel_hold[assert_slot_i]);
endmodule

// File: rtl/irq_trigger_ctrl.sv
module irq_trigger_ctrl #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'h04D0,
  parameter logic [7:0]  LO_MASK    = 8'hF8,
  parameter logic [7:0]  HI_MASK    = 8'hDE,
  parameter logic [15:0] FIXED_EDGE = 16'h2107,
  parameter int unsigned NUM_SLOTS  = 32,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              steer_en_i,
  input  logic              pri_level_mode_i,
  input  logic              sec_level_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [3:0]        query_irq_i,
  output logic              query_level_o,
  input  logic              assert_vld_i,
  input  logic [SLOT_W-1:0] assert_slot_i,
  input  logic [3:0]        assert_irq_i,
  output logic              assert_taken_o,
  input  logic              release_vld_i,
  input  logic [SLOT_W-1:0] release_slot_i,
  input  logic [3:0]        release_irq_i,
  output logic [15:0]       line_active_o
);
  import itc_pkg::*;

  logic [NUM_IRQ-1:0] mode_bits;
  logic [NUM_IRQ-1:0] line_level;

  itc_regfile #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .LO_MASK  (LO_MASK),
    .HI_MASK  (HI_MASK)
  ) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .steer_en_i (steer_en_i),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .mode_bits_o(mode_bits)
  );

  itc_mode_lookup #(
    .FIXED_EDGE(FIXED_EDGE)
  ) u_lookup (
    .steer_en_i      (steer_en_i),
    .pri_level_mode_i(pri_level_mode_i),
    .sec_level_mode_i(sec_level_mode_i),
    .mode_bits_i     (mode_bits),
    .line_level_o    (line_level)
  );

  assign query_level_o = line_level[query_irq_i];

  itc_hold_tracker #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .line_level_i  (line_level),
    .assert_vld_i  (assert_vld_i),
    .assert_slot_i (assert_slot_i),
    .assert_irq_i  (assert_irq_i),
    .release_vld_i (release_vld_i),
    .release_slot_i(release_slot_i),
    .release_irq_i (release_irq_i),
    .assert_taken_o(assert_taken_o),
    .line_active_o (line_active_o)
  );
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] BASE_ADDR  = 16'h04D0,
  parameter logic [15:0] FIXED_EDGE = 16'h2107,
  parameter int unsigned SLOT_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              steer_en_i,
  input logic              pri_level_mode_i,
  input logic              sec_level_mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic [3:0]        query_irq_i,
  input logic              query_level_o,
  input logic              assert_vld_i,
  input logic [SLOT_W-1:0] assert_slot_i,
  input logic [3:0]        assert_irq_i,
  input logic              assert_taken_o,
  input logic              release_vld_i,
  input logic [SLOT_W-1:0] release_slot_i,
  input logic [3:0]        release_irq_i,
  input logic [15:0]       line_active_o,
  input logic [15:0]       line_level
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic port_hit;
  assign port_hit = steer_en_i && (addr_i[ADDR_W-1:1] == BASE[ADDR_W-1:1]);

  logic same_release;
  assign same_release = release_vld_i && (release_irq_i == assert_irq_i) &&
                        (release_slot_i == assert_slot_i);

  p_rdata_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  p_miss_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !port_hit) |=> (rdata_o == 8'h00));

  p_fixed_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_en_i && FIXED_EDGE[query_irq_i]) |-> !query_level_o);

  p_fallback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steer_en_i |-> (query_level_o == (query_irq_i[3] ? sec_level_mode_i : pri_level_mode_i)));

  p_edge_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assert_vld_i && !line_level[assert_irq_i]) |-> assert_taken_o);

  p_hold_active_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (assert_vld_i && line_level[assert_irq_i] && !same_release)
      |=> line_active_o[$past(assert_irq_i)]);

  p_taken_needs_vld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    assert_taken_o |-> assert_vld_i);
endmodule

bind irq_trigger_ctrl itc_checker #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .FIXED_EDGE(FIXED_EDGE),
  .SLOT_W    (SLOT_W)
) u_itc_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .steer_en_i      (steer_en_i),
  .pri_level_mode_i(pri_level_mode_i),
  .sec_level_mode_i(sec_level_mode_i),
  .addr_i          (addr_i),
  .rd_i            (rd_i),
  .rdata_o         (rdata_o),
  .query_irq_i     (query_irq_i),
  .query_level_o   (query_level_o),
  .assert_vld_i    (assert_vld_i),
  .assert_slot_i   (assert_slot_i),
  .assert_irq_i    (assert_irq_i),
  .assert_taken_o  (assert_taken_o),
  .release_vld_i   (release_vld_i),
  .release_slot_i  (release_slot_i),
  .release_irq_i   (release_irq_i),
  .line_active_o   (line_active_o),
  .line_level      (line_level)
);

// File: tb/tb_irq_trigger_ctrl.sv
`timescale 1ns/1ps
module tb_irq_trigger_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        steer_en_i = 1'b1;
  logic        pri_level_mode_i = 1'b0;
  logic        sec_level_mode_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [3:0]  query_irq_i = '0;
  logic        query_level_o;
  logic        assert_vld_i = 1'b0;
  logic [4:0]  assert_slot_i = '0;
  logic [3:0]  assert_irq_i = '0;
  logic        assert_taken_o;
  logic        release_vld_i = 1'b0;
  logic [4:0]  release_slot_i = '0;
  logic [3:0]  release_irq_i = '0;
  logic [15:0] line_active_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  irq_trigger_ctrl dut (.*);

  // {address, write data, expected readback}
  localparam logic [31:0] VEC [8] = '{
    {16'h04D0, 8'hFF, 8'hF8},
    {16'h04D1, 8'hFF, 8'hDE},
    {16'h04D0, 8'hA5, 8'hA0},
    {16'h04D1, 8'h21, 8'h00},
    {16'h04D1, 8'h5A, 8'h5A},
    {16'h04D0, 8'h07, 8'h00},
    {16'h04D0, 8'h08, 8'h08},
    {16'h04D1, 8'hFE, 8'hDE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic query(input logic [3:0] n, output logic lvl);
    query_irq_i = n;
    #1;
    lvl = query_level_o;
  endtask

  // returns taken flag seen in the asserting cycle
  task automatic slot_assert(input logic [4:0] s, input logic [3:0] n, output logic tk);
    @(negedge clk_i);
    assert_slot_i = s; assert_irq_i = n; assert_vld_i = 1'b1;
    #1;
    tk = assert_taken_o;
    @(negedge clk_i);
    assert_vld_i = 1'b0;
  endtask

  task automatic slot_release(input logic [4:0] s, input logic [3:0] n);
    @(negedge clk_i);
    release_slot_i = s; release_irq_i = n; release_vld_i = 1'b1;
    @(negedge clk_i);
    release_vld_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    logic       lvl;
    logic       tk;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 reset state
    bus_read(16'h04D0, rd); check("R7 lower after reset", rd, 8'h00);
    bus_read(16'h04D1, rd); check("R7 upper after reset", rd, 8'h00);
    check("R7 no holds after reset", line_active_o, 16'h0000);

    // R1 mask table
    for (int i = 0; i < 8; i++) begin
      bus_write(VEC[i][31:16], VEC[i][15:8]);
      bus_read(VEC[i][31:16], rd);
      check($sformatf("R1 vector %0d", i), rd, VEC[i][7:0]);
    end

    // R1 rdata holds without read strobe
    repeat (3) @(negedge clk_i);
    check("R1 rdata holds", rdata_o, 8'hDE);

    // R2 out-of-range address
    bus_write(16'h04D2, 8'h00);
    bus_write(16'h14D0, 8'h00);
    bus_read(16'h04D2, rd); check("R2 miss read", rd, 8'h00);
    bus_read(16'h04D1, rd); check("R2 upper unchanged", rd, 8'hDE);

    // lower = F8, upper = DE from here
    bus_write(16'h04D0, 8'hFF);
    query(4'd3, lvl);  check("R3 irq3 level", lvl, 1'b1);
    query(4'd9, lvl);  check("R3 irq9 level", lvl, 1'b1);
    query(4'd13, lvl); check("R4 irq13 edge", lvl, 1'b0);
    query(4'd8, lvl);  check("R4 irq8 edge", lvl, 1'b0);
    query(4'd1, lvl);  check("R4 irq1 edge", lvl, 1'b0);
    bus_write(16'h04D1, 8'h02);
    query(4'd9, lvl);  check("R3 irq9 single bit", lvl, 1'b1);
    query(4'd10, lvl); check("R3 irq10 cleared", lvl, 1'b0);

    // R5 fallback, R6 decode off
    steer_en_i = 1'b0; pri_level_mode_i = 1'b1; sec_level_mode_i = 1'b0;
    query(4'd0, lvl);  check("R5 irq0 from primary", lvl, 1'b1);
    query(4'd9, lvl);  check("R5 irq9 from secondary", lvl, 1'b0);
    pri_level_mode_i = 1'b0; sec_level_mode_i = 1'b1;
    query(4'd13, lvl); check("R5 irq13 from secondary", lvl, 1'b1);
    query(4'd5, lvl);  check("R5 irq5 from primary", lvl, 1'b0);
    bus_write(16'h04D0, 8'h00);
    bus_read(16'h04D0, rd); check("R6 read decode off", rd, 8'h00);
    steer_en_i = 1'b1;
    bus_read(16'h04D0, rd); check("R6 write ignored", rd, 8'hF8);

    // R8 / R10 shared level line 5
    slot_assert(5'd3, 4'd5, tk); check("R8 first assert taken", tk, 1'b1);
    check("R10 line5 active", line_active_o[5], 1'b1);
    slot_assert(5'd3, 4'd5, tk); check("R8 repeat ignored", tk, 1'b0);
    slot_assert(5'd7, 4'd5, tk); check("R8 second slot taken", tk, 1'b1);
    slot_release(5'd3, 4'd5);
    check("R10 still held by slot 7", line_active_o[5], 1'b1);
    slot_assert(5'd7, 4'd5, tk); check("R10 slot 7 kept", tk, 1'b0);
    slot_assert(5'd3, 4'd5, tk); check("R10 slot 3 cleared", tk, 1'b1);
    slot_release(5'd3, 4'd5);
    slot_release(5'd7, 4'd5);
    check("R10 line5 released", line_active_o[5], 1'b0);

    // R10 release wins over same-cycle assert
    @(negedge clk_i);
    assert_slot_i = 5'd31; assert_irq_i = 4'd5; assert_vld_i = 1'b1;
    release_slot_i = 5'd31; release_irq_i = 4'd5; release_vld_i = 1'b1;
    @(negedge clk_i);
    assert_vld_i = 1'b0; release_vld_i = 1'b0;
    check("R10 release precedence", line_active_o[5], 1'b0);

    // R9 edge line 10
    slot_assert(5'd1, 4'd10, tk); check("R9 edge taken", tk, 1'b1);
    check("R9 no hold on edge", line_active_o[10], 1'b0);
    slot_assert(5'd1, 4'd10, tk); check("R9 edge repeat taken", tk, 1'b1);

    // R7 reset mid-run clears registers and holds
    slot_assert(5'd2, 4'd4, tk);
    check("R8 line4 held before reset", line_active_o[4], 1'b1);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check("R7 holds cleared", line_active_o, 16'h0000);
    bus_read(16'h04D0, rd); check("R7 lower cleared", rd, 8'h00);
    query(4'd4, lvl); check("R7 irq4 edge after reset", lvl, 1'b0);

    finish_run();
  end
endmodule